// File: doc/BRIEF.md
# Synchronous Serial Master with Buffered Host Side

The block is a full-duplex synchronous serial master (SPI-style). A host loads characters into a one-entry transmit holding register. It picks received characters up from a receive register and polls two flags. One flag says there is room for another transmit character. The other says a received character is waiting. Every serial clock cycle moves one bit out on `mosi` and one bit in from `miso`. A single active-low select frames each character.

Static configuration inputs set the following:

- serial clock idle level and sampling phase, giving all four modes
- bit order
- a 7-bit or 8-bit character
- a 16-bit half-period divisor, supplied as two byte fields
- an internal loopback
- a soft-hold input that parks the whole block in its default state

The transmit side is double-buffered. If the host has already queued the next character when the current one ends, that character starts at once and the select stays asserted.

Top module: `spi_host_ctrl`

## Requirements
- R1: While `rst_n` is low or `cfg_hold` is high, the block sits in its default state from the next clock on: `cs_n`=1, `sclk` at its idle level, `tx_ready`=1, `rx_done`=0, `rx_overrun`=0. Any queued byte is dropped, and `tx_wr` pulses made during the hold start no transfer.
- R2: Each character moves N bits out on `mosi` and N bits in from `miso`, one per serial clock cycle, where N is 8 (`cfg_seven`=0) or 7 (`cfg_seven`=1). The received character then appears on `rx_data`.
- R3: Whenever `cs_n` is high, `sclk` equals `cfg_cpol`. With `cfg_cpol`=1 the clock idles high.
- R4: With `cfg_cpha`=0 the first data bit is valid before the first clock edge, and both sides capture on the first (leading) edge of each cycle. With `cfg_cpha`=1 data changes on the leading edge and is captured on the trailing edge.
- R5: With `cfg_lsb_first`=0 the most significant bit goes first, so 0xBB leaves as 1,0,1,1,1,0,1,1. With `cfg_lsb_first`=1 bit 0 goes first. Reception uses the same order.
- R6: In 7-bit mode only `tx_data[6:0]` is sent, and the received character fills `rx_data[6:0]` with `rx_data[7]`=0.
- R7: `tx_ready` drops in the clock after a `tx_wr`. It rises again as soon as the byte moves into the shifter, while that character is still shifting.
- R8: `rx_done` rises when a complete character is written to `rx_data`. It is cleared by a `rx_rd` pulse. If `rx_rd` falls in the same clock as a completion, `rx_done` stays set and holds the new character.
- R9: With `cfg_loop`=1 the receive side takes the outgoing `mosi` stream, so each character comes back unchanged and `miso` is ignored.
- R10: Each half-period of `sclk` lasts D system clocks, where D = {`cfg_div_hi`,`cfg_div_lo`}. A D of 0 acts as 1.
- R11: `cs_n` stays low for the whole character. A byte queued before the current character ends follows without `cs_n` rising and with no extra half-period gap.
- R12: A completion while `rx_done` is still set, with no `rx_rd` in that clock, sets `rx_overrun` and overwrites `rx_data`. `rx_rd` clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Soft hold: parks the block in its default state |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sampling phase: 0 = capture on leading edge, 1 = capture on trailing edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_seven | input | 1 | 1 = 7-bit characters held in the low bits |
| cfg_loop | input | 1 | Internal loopback from mosi to the receiver |
| cfg_div_lo | input | 8 | Half-period divisor, low byte |
| cfg_div_hi | input | 8 | Half-period divisor, high byte |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to transmit |
| tx_ready | output | 1 | Transmit holding register is empty |
| rx_rd | input | 1 | Read strobe for the received character |
| rx_data | output | 8 | Last received character |
| rx_done | output | 1 | A received character is waiting |
| rx_overrun | output | 1 | A character was lost before being read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
Two events can fall in the same clock: the host read that clears `rx_done`, and a character completion that sets it. The bench provokes this by holding `rx_rd` high across the whole second character of a pair, so the read is present on the completion edge whatever its exact cycle. Right after `cs_n` rises, the bench expects `rx_done` still set, `rx_overrun` clear and the second character on `rx_data`. A second overlap, a queued write meeting the end of a character, is judged by select continuity and by the half-period spacing across the character boundary.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // Framing options handed from the host side to the shift engine
   typedef struct packed {
      logic cpha;
      logic lsb_first;
      logic short_char;
      logic loop_en;
   } spi_fmt_t;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt == div_val - DIV_W'(1));
   assign tick = en && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en || wrap)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
   import spi_host_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  spi_fmt_t          fmt,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              miso,
   output logic              busy,
   output logic              sclk_raw,
   output logic              mosi_bit,
   output logic              done,
   output logic [DATA_W-1:0] done_data
);

   localparam int EDGE_W   = $clog2(2 * DATA_W) + 1;
   localparam int LAST_FUL = 2 * DATA_W - 1;
   localparam int LAST_SHT = 2 * DATA_W - 3;

   logic [EDGE_W-1:0] edge_cnt;
   logic [EDGE_W-1:0] last_edge;
   logic [DATA_W-1:0] out_sr, in_sr, in_nxt;
   logic [DATA_W-1:0] ld_rev, in_rev, load_vec;
   logic              sclk_q, cap, shf, rx_in;

   // Mirror images used for least-significant-first framing
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign ld_rev[gi] = load_data[DATA_W-1-gi];
      assign in_rev[gi] = in_nxt[DATA_W-1-gi];
   end

   assign last_edge = fmt.short_char ? EDGE_W'(LAST_SHT) : EDGE_W'(LAST_FUL);

   // Capture on the leading edge for phase 0, trailing edge for phase 1;
   // the outgoing bit advances on the edge that follows a capture.
   assign cap = (edge_cnt[0] == fmt.cpha);
   assign shf = !cap && (edge_cnt != '0);

   assign mosi_bit = busy ? out_sr[DATA_W-1] : 1'b0;
   assign rx_in    = fmt.loop_en ? mosi_bit : miso;
   assign in_nxt   = cap ? {in_sr[DATA_W-2:0], rx_in} : in_sr;
   assign done     = busy && tick && (edge_cnt == last_edge);
   assign sclk_raw = sclk_q;

   always_comb begin
      if (!fmt.lsb_first)
         done_data = in_nxt;
      else if (fmt.short_char)
         done_data = in_rev >> 1;
      else
         done_data = in_rev;
   end

   always_comb begin
      if (fmt.lsb_first)
         load_vec = ld_rev;
      else if (fmt.short_char)
         load_vec = load_data << 1;
      else
         load_vec = load_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sclk_q   <= 1'b0;
         edge_cnt <= '0;
         out_sr   <= '0;
         in_sr    <= '0;
      end else if (hold) begin
         busy     <= 1'b0;
         sclk_q   <= 1'b0;
         edge_cnt <= '0;
         out_sr   <= '0;
         in_sr    <= '0;
      end else if (load) begin
         busy     <= 1'b1;
         sclk_q   <= 1'b0;
         edge_cnt <= '0;
         out_sr   <= load_vec;
         in_sr    <= '0;
      end else if (busy && tick) begin
         sclk_q   <= ~sclk_q;
         edge_cnt <= edge_cnt + EDGE_W'(1);
         in_sr    <= in_nxt;
         if (shf)
            out_sr <= {out_sr[DATA_W-2:0], 1'b0};
         if (done)
            busy <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_hold,
   input  logic                 cfg_cpol,
   input  logic                 cfg_cpha,
   input  logic                 cfg_lsb_first,
   input  logic                 cfg_seven,
   input  logic                 cfg_loop,
   input  logic [DIV_W/2-1:0]   cfg_div_lo,
   input  logic [DIV_W/2-1:0]   cfg_div_hi,
   input  logic                 tx_wr,
   input  logic [DATA_W-1:0]    tx_data,
   output logic                 tx_ready,
   input  logic                 rx_rd,
   output logic [DATA_W-1:0]    rx_data,
   output logic                 rx_done,
   output logic                 rx_overrun,
   output logic                 sclk,
   output logic                 mosi,
   input  logic                 miso,
   output logic                 cs_n
);

   if (DATA_W < 2) begin : g_bad_data
      $error("spi_host_ctrl: DATA_W must be at least 2");
   end
   if ((DIV_W < 2) || (DIV_W % 2 != 0)) begin : g_bad_div
      $error("spi_host_ctrl: DIV_W must be even and at least 2");
   end

   spi_fmt_t          fmt;
   logic [DIV_W-1:0]  div_raw, eff_div;
   logic              tick, load;
   logic              eng_busy, eng_sclk, eng_mosi, eng_done;
   logic [DATA_W-1:0] eng_data;
   logic [DATA_W-1:0] tx_buf, rx_buf;
   logic              buf_full, done_q, ovr_q;

   assign fmt     = '{cpha: cfg_cpha, lsb_first: cfg_lsb_first,
                      short_char: cfg_seven, loop_en: cfg_loop};
   assign div_raw = {cfg_div_hi, cfg_div_lo};
   assign eff_div = (div_raw == '0) ? DIV_W'(1) : div_raw;
   assign load    = buf_full && !cfg_hold && (!eng_busy || eng_done);

   spi_half_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (eng_busy && !cfg_hold),
      .div_val (eff_div),
      .tick    (tick)
   );

   spi_bit_engine #(.DATA_W(DATA_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (cfg_hold),
      .fmt       (fmt),
      .tick      (tick),
      .load      (load),
      .load_data (tx_buf),
      .miso      (miso),
      .busy      (eng_busy),
      .sclk_raw  (eng_sclk),
      .mosi_bit  (eng_mosi),
      .done      (eng_done),
      .done_data (eng_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         tx_buf   <= '0;
         rx_buf   <= '0;
         done_q   <= 1'b0;
         ovr_q    <= 1'b0;
      end else if (cfg_hold) begin
         buf_full <= 1'b0;
         tx_buf   <= '0;
         rx_buf   <= '0;
         done_q   <= 1'b0;
         ovr_q    <= 1'b0;
      end else begin
         if (tx_wr) begin
            tx_buf   <= tx_data;
            buf_full <= 1'b1;
         end else if (load) begin
            buf_full <= 1'b0;
         end

         if (eng_done) begin
            rx_buf <= eng_data;
            done_q <= 1'b1;
         end else if (rx_rd) begin
            done_q <= 1'b0;
         end

         if (rx_rd)
            ovr_q <= 1'b0;
         else if (eng_done && done_q)
            ovr_q <= 1'b1;
      end
   end

   assign tx_ready   = !buf_full;
   assign rx_data    = rx_buf;
   assign rx_done    = done_q;
   assign rx_overrun = ovr_q;
   assign sclk       = eng_sclk ^ cfg_cpol;
   assign mosi       = eng_mosi;
   assign cs_n       = !eng_busy;

endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_hold,
   input logic cfg_cpol,
   input logic tx_wr,
   input logic rx_rd,
   input logic char_done,
   input logic tx_ready,
   input logic rx_done,
   input logic rx_overrun,
   input logic sclk,
   input logic cs_n
);

   // R1
   hold_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hold |=> (cs_n && tx_ready && !rx_done && !rx_overrun));

   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (sclk == cfg_cpol));

   // R7
   wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && !cfg_hold) |=> !tx_ready);

   // R8
   rd_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !char_done) |=> !rx_done);

   // R8
   done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> !$past(cs_n));

   // R12
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> ($past(rx_done) && !$past(rx_rd)));

   // R11
   sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sclk) && $stable(cfg_cpol)) |-> !$past(cs_n));

endmodule

bind spi_host_ctrl spi_host_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_hold   (cfg_hold),
   .cfg_cpol   (cfg_cpol),
   .tx_wr      (tx_wr),
   .rx_rd      (rx_rd),
   .char_done  (eng_done),
   .tx_ready   (tx_ready),
   .rx_done    (rx_done),
   .rx_overrun (rx_overrun),
   .sclk       (sclk),
   .cs_n       (cs_n)
);

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_hold = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic       cfg_lsb = 1'b0, cfg_seven = 1'b0, cfg_loop = 1'b0;
   logic [7:0] div_lo = 8'd1, div_hi = 8'd0;
   logic       tx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_ready, rx_done, rx_overrun, sclk, mosi, cs_n;
   logic       miso = 1'b0;
   logic [7:0] rx_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   spi_host_ctrl u_spi_host_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb), .cfg_seven(cfg_seven),
      .cfg_loop(cfg_loop), .cfg_div_lo(div_lo), .cfg_div_hi(div_hi),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd),
      .rx_data(rx_data), .rx_done(rx_done), .rx_overrun(rx_overrun),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // ---------------- slave model and monitors ----------------
   int         cyc = 0;
   logic       mosi_n = 1'b0, cs_n_n = 1'b1;
   logic [7:0] s_tx = 8'h00, s_acc = 8'h00, s_got = 8'h00, s_seq = 8'h00;
   int         s_cnt = 0;
   int         last_e = 0, exp_half = 1, bad_half = 0;
   bit         have_e = 1'b0;
   int         cs_falls = 0, cs_rises = 0;

   function automatic int nbits(logic s);
      return s ? 7 : 8;
   endfunction

   function automatic logic sbit(logic [7:0] d, int i, logic lsb, logic s);
      return lsb ? d[i] : d[nbits(s)-1-i];
   endfunction

   function automatic logic [7:0] mask8(logic [7:0] v, logic s);
      return s ? {1'b0, v[6:0]} : v;
   endfunction

   always @(negedge clk) begin
      cyc++;
      mosi_n = mosi;
      cs_n_n = cs_n;
   end

   always @(negedge cs_n) begin
      s_cnt  = 0;
      s_acc  = 8'h00;
      have_e = 1'b0;
      cs_falls++;
      miso   = sbit(s_tx, 0, cfg_lsb, cfg_seven);
   end

   always @(posedge cs_n) if (rst_n) cs_rises++;

   always @(sclk) begin
      if (rst_n && !cs_n_n) begin
         if (have_e && (cyc - last_e != exp_half)) bad_half++;
         last_e = cyc;
         have_e = 1'b1;
         if ((sclk != cfg_cpol) ^ cfg_cpha) begin
            s_acc[cfg_lsb ? s_cnt : nbits(cfg_seven)-1-s_cnt] = mosi_n;
            s_seq = {s_seq[6:0], mosi_n};
            s_cnt++;
            if (s_cnt == nbits(cfg_seven)) begin
               s_got = s_acc;
               s_acc = 8'h00;
               s_cnt = 0;
               miso  = sbit(s_tx, 0, cfg_lsb, cfg_seven);
            end
         end else if (s_cnt > 0) begin
            miso = sbit(s_tx, s_cnt, cfg_lsb, cfg_seven);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic pol, input logic pha, input logic lsb,
                          input logic sev, input logic lp, input logic [15:0] dv);
      @(negedge clk);
      cfg_cpol = pol; cfg_cpha = pha; cfg_lsb = lsb;
      cfg_seven = sev; cfg_loop = lp;
      {div_hi, div_lo} = dv;
      exp_half = (dv == 16'd0) ? 1 : int'(dv);
   endtask

   task automatic host_write(input logic [7:0] v);
      @(negedge clk);
      tx_data = v; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic host_read();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!rx_done);
   endtask

   task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input string tag);
      logic [7:0] exp_rx;
      s_tx = sl;
      bad_half = 0;
      host_write(tx);
      wait_done();
      exp_rx = cfg_loop ? mask8(tx, cfg_seven) : mask8(sl, cfg_seven);
      chk(rx_data == exp_rx, {tag, " R2 received char"}, rx_data, exp_rx);
      chk(s_got == mask8(tx, cfg_seven), {tag, " R2 slave saw char"}, s_got, mask8(tx, cfg_seven));
      chk(bad_half == 0, {tag, " R10 half-period spacing"}, bad_half, 0);
      chk(sclk == cfg_cpol && cs_n, {tag, " R3 idle level"}, sclk, cfg_cpol);
      host_read();
      chk(!rx_done, {tag, " R8 read clears flag"}, rx_done, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int rises0, falls0, lp;
      void'($urandom(32'h5EED_0382));
      repeat (3) @(negedge clk);
      // R1 reset defaults
      chk(cs_n && tx_ready && !rx_done && !rx_overrun, "R1 reset defaults",
          {cs_n, tx_ready, rx_done, rx_overrun}, 4'b1100);
      chk(sclk == 1'b0, "R3 reset idle level", sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: 0xBB MSB-first, mode 0
      set_cfg(0, 0, 0, 0, 0, 16'd2);
      xfer(8'hBB, 8'h5D, "mode0");
      chk(s_seq == 8'hBB, "R5 msb-first bit stream", s_seq, 8'hBB);
      set_cfg(0, 0, 1, 0, 0, 16'd2);
      xfer(8'hBB, 8'h5D, "lsb");
      chk(s_seq == 8'hDD, "R5 lsb-first bit stream", s_seq, 8'hDD);

      // R4: all four clock modes
      for (int m = 0; m < 4; m++) begin
         set_cfg(m[1], m[0], 0, 0, 0, 16'd1);
         xfer(8'hAA, 8'h5D, "R4 mode");
         xfer(8'h5D, 8'hAA, "R4 mode");
      end

      // R6: 7-bit characters
      set_cfg(1, 0, 0, 1, 0, 16'd1);
      xfer(8'hFF, 8'hD5, "R6 msb");
      chk(rx_data == 8'h55, "R6 rx high bit zero", rx_data, 8'h55);
      set_cfg(0, 1, 1, 1, 0, 16'd3);
      xfer(8'hC3, 8'hB1, "R6 lsb");

      // R10: zero divisor and a two-byte divisor
      set_cfg(0, 0, 0, 0, 0, 16'd0);
      xfer(8'h96, 8'h3C, "R10 div0");
      set_cfg(0, 1, 0, 0, 0, 16'h0103);
      xfer(8'h21, 8'hE7, "R10 div259");

      // R9: loopback ignores miso
      set_cfg(1, 1, 0, 0, 1, 16'd1);
      xfer(8'h6B, 8'h94, "R9 loop");
      set_cfg(0, 0, 1, 1, 1, 16'd2);
      xfer(8'h4E, 8'hFF, "R9 loop7");

      // R7: ready drops after write, rises while the character still shifts
      set_cfg(0, 0, 0, 0, 1, 16'd2);
      @(negedge clk);
      tx_data = 8'h11; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      chk(!tx_ready, "R7 ready low after write", tx_ready, 0);
      @(negedge clk);
      chk(tx_ready && !cs_n, "R7 ready high while shifting", {tx_ready, cs_n}, 2'b10);
      wait_done();
      host_read();

      // R11 + R12: back-to-back characters, no read in between
      rises0 = cs_rises; bad_half = 0;
      host_write(8'hA5);
      @(negedge clk);
      host_write(8'h3C);
      wait_done();
      do @(negedge clk); while (!cs_n);
      chk(cs_rises - rises0 == 1, "R11 select held across pair", cs_rises - rises0, 1);
      chk(bad_half == 0, "R11 no gap between characters", bad_half, 0);
      chk(rx_overrun, "R12 overrun set", rx_overrun, 1);
      chk(rx_data == 8'h3C, "R12 newer char kept", rx_data, 8'h3C);
      host_read();
      chk(!rx_overrun && !rx_done, "R12 read clears overrun", {rx_overrun, rx_done}, 0);

      // R8: read strobe in the same clock as a completion
      host_write(8'h5A);
      wait_done();
      @(negedge clk);
      rx_rd = 1'b1;
      host_write(8'hC6);
      @(posedge cs_n);
      #1;
      chk(rx_done && !rx_overrun, "R8 completion wins over read",
          {rx_done, rx_overrun}, 2'b10);
      chk(rx_data == 8'hC6, "R8 new char present", rx_data, 8'hC6);
      rx_rd = 1'b0;
      host_read();

      // R1: soft hold in the middle of a character
      set_cfg(1, 0, 0, 0, 0, 16'd4);
      s_tx = 8'h00;
      host_write(8'hF0);
      repeat (6) @(negedge clk);
      tx_data = 8'h0F; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; cfg_hold = 1'b1;
      @(negedge clk);
      chk(cs_n && tx_ready && !rx_done && sclk == 1'b1, "R1 hold defaults",
          {cs_n, tx_ready, rx_done, sclk}, 4'b1101);
      falls0 = cs_falls;
      tx_data = 8'h77; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      @(negedge clk);
      cfg_hold = 1'b0;
      repeat (40) @(negedge clk);
      chk(cs_falls == falls0 && tx_ready && !rx_done, "R1 write in hold ignored",
          cs_falls - falls0, 0);

      // random mix
      for (int i = 0; i < 24; i++) begin
         lp = int'($urandom_range(0, 1));
         set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'(lp), 16'($urandom_range(0, 4)));
         xfer(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R2 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule